// File: doc/BRIEF.md
# Unrolled CORDIC Sine/Cosine Generator

This block turns a signed angle into its cosine and sine using ten chained shift-and-add micro-rotations in rotation mode. The angle is written in a degree-based code in which one LSB is 45/4096 of a degree, so 45° is the word 4096. The start vector is pre-scaled by the reciprocal of the CORDIC gain, so the last stage delivers cosine and sine directly in signed fixed point with 13 fraction bits, and no multiplier is needed.

The ten stages form one combinational chain. A single register bank at the output captures the result, so the latency is one clock and a new angle may be presented on every cycle. Angles whose magnitude exceeds a programmable limit, set just inside the ±99.7° region where the iteration converges, are refused: they raise no valid strobe and leave the outputs untouched.

The output stage is a two-state machine. EMPTY means no fresh result is on the outputs; FRESH means the outputs were loaded on the last edge. The transition ACCEPT (in_valid high with an in-range angle) leads from either state to FRESH. The transition IDLE (no accepted angle) leads from either state to EMPTY. Reset puts the machine in EMPTY.

Top module: `cordic_sincos`

## Requirements
- R1: `in_angle` is a signed 15-bit two's-complement code in which 4096 is 45°, so one LSB is 45/4096 degree and 8192 is 90°.
- R2: For an accepted angle, `out_cos` is a signed 15-bit word with 13 fraction bits (8192 is 1.0) within 24 LSB of the true cosine.
- R3: For an accepted angle, `out_sin` has the same format and lies within 24 LSB of the true sine.
- R4: An angle is accepted when `in_valid` is 1 and −9000 ≤ `in_angle` ≤ 9000; `out_valid` is 1 in the cycle after an accepted angle, including on consecutive accepted angles.
- R5: `out_valid` is 0 in the cycle after a cycle in which `in_valid` is 0.
- R6: An angle with magnitude above 9000 presented with `in_valid` at 1 is refused: `out_valid` is 0 in the next cycle and `out_cos`/`out_sin` keep their previous values.
- R7: While no angle is accepted, `out_cos` and `out_sin` hold their values.
- R8: While `rst_n` is 0, `out_valid`, `out_cos` and `out_sin` are all 0.
- R9: The limit angles +9000 and −9000 (about ±98.9°, negative cosine) are accepted and meet the accuracy of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Angle present on `in_angle` |
| in_angle | input | 15 | Signed angle code, 4096 = 45° |
| out_valid | output | 1 | Fresh result on the outputs |
| out_cos | output | 15 | Cosine, signed, 13 fraction bits |
| out_sin | output | 15 | Sine, signed, 13 fraction bits |

## Verification
The bench builds the block with its defaults: 15-bit data and angle words, ten stages, a start value of 4975 and an acceptance limit of 9000. Ten stages leave a residual angle near the smallest constant (10 codes, about 0.11°), which is why the accuracy window is 24 LSB; the 9000 limit brings the second-quadrant edge of convergence within reach, where the cosine turns negative and intermediate values are largest. The limit also lets a single code step (9000 against 9001) show the border between acceptance and refusal.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    // State of the output register bank
    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FRESH = 1'b1
    } out_state_e;

    // Arctangent of 2^-idx in the angle code (4096 per 45 degrees)
    function automatic int atan_code(input int idx);
        int r;
        case (idx)
            0:       r = 4096;
            1:       r = 2418;
            2:       r = 1277;
            3:       r = 648;
            4:       r = 325;
            5:       r = 162;
            6:       r = 81;
            7:       r = 40;
            8:       r = 20;
            9:       r = 10;
            10:      r = 5;
            11:      r = 3;
            default: r = 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int W   = 15,
    parameter int ZW  = 15,
    parameter int IDX = 0
) (
    input  logic signed [W-1:0]  x_in,
    input  logic signed [W-1:0]  y_in,
    input  logic signed [ZW-1:0] z_in,
    output logic signed [W-1:0]  x_out,
    output logic signed [W-1:0]  y_out,
    output logic signed [ZW-1:0] z_out
);
    import cordic_pkg::*;

    localparam int                 ATAN_I = atan_code(IDX);
    localparam logic signed [ZW-1:0] ATAN = ZW'(ATAN_I);

    logic signed [W-1:0] x_sh;
    logic signed [W-1:0] y_sh;

    always_comb begin
        x_sh = x_in >>> IDX;
        y_sh = y_in >>> IDX;
        if (!z_in[ZW-1]) begin
            x_out = x_in - y_sh;
            y_out = y_in + x_sh;
            z_out = z_in - ATAN;
        end else begin
            x_out = x_in + y_sh;
            y_out = y_in - x_sh;
            z_out = z_in + ATAN;
        end
    end

endmodule

// File: rtl/cordic_range_chk.sv
module cordic_range_chk #(
    parameter int ZW    = 15,
    parameter int LIMIT = 9000
) (
    input  logic signed [ZW-1:0] angle,
    output logic                 in_range
);
    localparam logic signed [ZW-1:0] LIM_P = ZW'(LIMIT);
    localparam logic signed [ZW-1:0] LIM_N = -LIM_P;

    always_comb begin
        in_range = (angle <= LIM_P) && (angle >= LIM_N);
    end

endmodule

// File: rtl/cordic_out_reg.sv
module cordic_out_reg #(
    parameter int W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic signed [W-1:0] cos_d,
    input  logic signed [W-1:0] sin_d,
    output logic                out_valid,
    output logic signed [W-1:0] cos_q,
    output logic signed [W-1:0] sin_q
);
    import cordic_pkg::*;

    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        unique case (state_q)
            OUT_EMPTY: state_d = accept ? OUT_FRESH : OUT_EMPTY;
            OUT_FRESH: state_d = accept ? OUT_FRESH : OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cos_q <= '0;
            sin_q <= '0;
        end else if (accept) begin
            cos_q <= cos_d;
            sin_q <= sin_d;
        end
    end

    assign out_valid = (state_q == OUT_FRESH);

    // R4
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cos_q) && $stable(sin_q) && !out_valid));

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
    parameter int DW        = 15,
    parameter int AW        = 15,
    parameter int ITER      = 10,
    parameter int X_INIT    = 4975,
    parameter int ANG_LIMIT = 9000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [AW-1:0] in_angle,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_cos,
    output logic signed [DW-1:0] out_sin
);
    localparam logic signed [DW-1:0] X0      = DW'(X_INIT);
    localparam int                   ONE_I   = 1 << (DW - 2);
    localparam logic signed [DW-1:0] BOUND   = DW'(ONE_I + 64);
    localparam logic signed [AW-1:0] RESID_B = AW'(32);

    logic signed [DW-1:0] x_s [ITER+1];
    logic signed [DW-1:0] y_s [ITER+1];
    logic signed [AW-1:0] z_s [ITER+1];
    logic                 angle_ok;
    logic                 accept;

    cordic_range_chk #(.ZW(AW), .LIMIT(ANG_LIMIT)) u_range (
        .angle    (in_angle),
        .in_range (angle_ok)
    );

    assign accept = in_valid && angle_ok;
    assign x_s[0] = X0;
    assign y_s[0] = '0;
    assign z_s[0] = in_angle;

    for (genvar g = 0; g < ITER; g++) begin : g_stage
        cordic_stage #(.W(DW), .ZW(AW), .IDX(g)) u_stage (
            .x_in  (x_s[g]),
            .y_in  (y_s[g]),
            .z_in  (z_s[g]),
            .x_out (x_s[g+1]),
            .y_out (y_s[g+1]),
            .z_out (z_s[g+1])
        );
    end

    cordic_out_reg #(.W(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cos_d     (x_s[ITER]),
        .sin_d     (y_s[ITER]),
        .out_valid (out_valid),
        .cos_q     (out_cos),
        .sin_q     (out_sin)
    );

    // R2 R3: the chain drives the residual angle close to zero
    resid_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (z_s[ITER] <= RESID_B && z_s[ITER] >= -RESID_B));

    // R6
    reject_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !angle_ok) |=> (!out_valid && $stable(out_cos) && $stable(out_sin)));

    // R2
    cos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cos <= BOUND && out_cos >= -BOUND));

    // R3
    sin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sin <= BOUND && out_sin >= -BOUND));

endmodule

// File: tb/tb_cordic_sincos.sv
module tb_cordic_sincos;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [14:0] in_angle = '0;
    logic               out_valid;
    logic signed [14:0] out_cos;
    logic signed [14:0] out_sin;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    localparam int TOL = 24;

    always #10 clk = ~clk;

    cordic_sincos dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_angle  (in_angle),
        .out_valid (out_valid),
        .out_cos   (out_cos),
        .out_sin   (out_sin)
    );

    function automatic int ideal(input int code, input bit want_sin);
        real deg = code * 45.0 / 4096.0;
        real rad = deg * 3.14159265358979 / 180.0;
        real v   = want_sin ? $sin(rad) : $cos(rad);
        return $rtoi(v * 8192.0 + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp);
        checks++;
        if (act > exp + TOL || act < exp - TOL) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, TOL);
        end
    endtask

    // One accepted angle, checked one cycle later (R1 coding)
    task automatic run_angle(input int code, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_angle = 15'(code);
        @(negedge clk);
        in_valid = 1'b0;
        check_eq({"R4 valid ", req}, int'(out_valid), 1);
        check_near({"R2 cos ", req}, int'(out_cos), ideal(code, 1'b0));
        check_near({"R3 sin ", req}, int'(out_sin), ideal(code, 1'b1));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R8 valid", int'(out_valid), 0);
        check_eq("R8 cos", int'(out_cos), 0);
        check_eq("R8 sin", int'(out_sin), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_key_angles;
        run_angle(0,     "R1 0deg");
        run_angle(2731,  "R1 30deg");
        run_angle(-2731, "R1 -30deg");
        run_angle(4096,  "R1 45deg");
        run_angle(-4096, "R1 -45deg");
        run_angle(8192,  "R1 90deg");
        run_angle(-8192, "R1 -90deg");
        run_angle(2276,  "R1 25deg");
    endtask

    task automatic t_limits;
        run_angle(9000,  "R9 +limit");
        run_angle(-9000, "R9 -limit");
    endtask

    task automatic t_random;
        for (int k = 0; k < 40; k++) begin
            int a;
            a = int'($urandom_range(18000, 0)) - 9000;
            run_angle(a, "random");
        end
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1;
        in_angle = 15'(1000);
        @(negedge clk);
        check_eq("R4 b2b first valid", int'(out_valid), 1);
        check_near("R2 b2b first cos", int'(out_cos), ideal(1000, 1'b0));
        in_angle = 15'(-6000);
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R4 b2b second valid", int'(out_valid), 1);
        check_near("R3 b2b second sin", int'(out_sin), ideal(-6000, 1'b1));
    endtask

    task automatic t_hold;
        int c0;
        int s0;
        run_angle(3500, "R7 setup");
        c0 = int'(out_cos);
        s0 = int'(out_sin);
        in_angle = 15'(-7000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_eq("R5 idle valid", int'(out_valid), 0);
            check_eq("R7 idle cos", int'(out_cos), c0);
            check_eq("R7 idle sin", int'(out_sin), s0);
        end
    endtask

    task automatic t_reject;
        int c0;
        int s0;
        run_angle(-1500, "R6 setup");
        c0 = int'(out_cos);
        s0 = int'(out_sin);
        @(negedge clk);
        in_valid = 1'b1;
        in_angle = 15'(9001);
        @(negedge clk);
        check_eq("R6 9001 valid", int'(out_valid), 0);
        check_eq("R6 9001 cos", int'(out_cos), c0);
        check_eq("R6 9001 sin", int'(out_sin), s0);
        in_angle = 15'(-12000);
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R6 -12000 valid", int'(out_valid), 0);
        check_eq("R6 -12000 cos", int'(out_cos), c0);
        check_eq("R6 -12000 sin", int'(out_sin), s0);
    endtask

    initial begin
        t_reset();
        t_key_angles();
        t_limits();
        t_back_to_back();
        t_hold();
        t_reject();
        t_random();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule